// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial slave that gives a host access to a small bank of control registers. The wires are a serial clock, an active-low frame line, a data input and a data output. Each command is one 16-bit word, sent most significant bit first while the frame line is low. The word selects a register, says whether it is a read or a write, and carries a 10-bit value.

Twelve writable 10-bit registers are driven straight onto a parallel output bus for the rest of the chip. Four more addresses are read-only. Their values come from a parallel status input, such as peak-level detectors that clear when they are read.

The serial clock must run continuously, and it may be unrelated to the system clock. Every finished read and every accepted write is passed into the system clock domain as a one-cycle pulse, together with its address. A clear-on-read source can use that pulse to reset itself.

Top module: `ctl_spi_regs`

## Requirements
- R1: While reset is low, and after it is released, every writable register holds its value from the `CTRL_INIT` parameter. Register i sits in bits [10*i+9 : 10*i] of `ctrl_out`.
- R2: A frame is the bits sampled on rising `sck` edges while `frm_n` is low, most significant bit first.
  - Word bits 15..12 are the address.
  - Bit 11 is the direction flag, where 0 means write.
  - Bit 10 is ignored.
  - Bits 9..0 are the value.
  - If the frame held exactly 16 bits and the direction is write to an address from 0 to 11, that register takes the value on the first rising `sck` edge that sees `frm_n` high again. No other register changes.
- R3: On a read, `sdo` presents the 10-bit value of the addressed register most significant bit first. The bits appear on the rising `sck` edges that sample word bits 9 down to 0. `sdo` changes on falling `sck` edges.
- R4: A read of an address from 12 to 15 returns slice (address−12) of `status_in`, that is bits [10*(a−12)+9 : 10*(a−12)].
- R5: Each accepted write gives one single-cycle `wr_stb` pulse in the `clk` domain, with the written address on `ev_addr`.
- R6: Each complete 16-bit read frame, whatever its address, gives one single-cycle `rd_ack` pulse in the `clk` domain, with the read address on `ev_addr`.
- R7: A write to an address from 12 to 15 changes no register and gives no `wr_stb`.
- R8: A frame of fewer or more than 16 bits is discarded. No register changes, and there is no `wr_stb` and no `rd_ack`.
- R9: `sdo` is low whenever `frm_n` has been high across a whole `sck` period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the event pulses |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sck | input | 1 | Continuous serial clock |
| frm_n | input | 1 | Frame line, low while a word is shifted |
| sdi | input | 1 | Serial data in, sampled on rising `sck` |
| sdo | output | 1 | Serial read data, driven on falling `sck` |
| status_in | input | 40 | Four 10-bit read-only status words for addresses 12 to 15 |
| ctrl_out | output | 120 | Twelve 10-bit control registers |
| wr_stb | output | 1 | One-cycle pulse in `clk` per accepted write |
| rd_ack | output | 1 | One-cycle pulse in `clk` per completed read |
| ev_addr | output | 4 | Address of the last reported event |

## Verification
Some rules are checked by assertions on every clock edge:
- the bit counter never runs past its saturation value;
- the register bank stays unchanged on every edge that is not a commit, and also on a commit aimed at a read-only address;
- `sdo` stays low outside a frame;
- `wr_stb` never lasts longer than one system cycle.

Other behaviour can only be shown by the bench scenarios:
- that bits are taken in the right order and the fields decode correctly;
- that read data appears in exactly the right bit slots, and that status words are picked by address;
- that truncated and overlong frames are dropped;
- that the event pulses arrive once per frame with the correct address.

// File: rtl/ctl_spi_regs.sv
module ctl_spi_regs #(
  parameter int AW = 4,
  parameter int DW = 10,
  parameter int NCTRL = 12,
  parameter logic [NCTRL*DW-1:0] CTRL_INIT = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck,
  input  logic                   frm_n,
  input  logic                   sdi,
  output logic                   sdo,
  input  logic [(2**AW-NCTRL)*DW-1:0] status_in,
  output logic [NCTRL*DW-1:0]    ctrl_out,
  output logic                   wr_stb,
  output logic                   rd_ack,
  output logic [AW-1:0]          ev_addr
);
  localparam int HDR = AW + 2;
  localparam int FW = HDR + DW;
  localparam int NSTAT = 2**AW - NCTRL;
  localparam int CW = $clog2(FW + 2);
  localparam int SW = (NSTAT > 1) ? $clog2(NSTAT) : 1;
  localparam logic [AW-1:0] LAST_CTRL = AW'(NCTRL - 1);
  localparam logic [CW-1:0] FULL = CW'(FW);
  localparam logic [CW-1:0] OVER = CW'(FW + 1);

  logic [DW-1:0] bank [NCTRL];
  logic [DW-1:0] stat [NSTAT];
  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          latch_q, ev_tgl, ev_rw;
  logic [AW-1:0] ev_addr_r;
  logic [DW-1:0] tx;
  logic [2:0]    sy;

  genvar g;
  generate
    for (g = 0; g < NCTRL; g++) begin : g_out
      assign ctrl_out[g*DW +: DW] = bank[g];
    end
    for (g = 0; g < NSTAT; g++) begin : g_stat
      assign stat[g] = status_in[g*DW +: DW];
    end
  endgenerate

  wire [AW-1:0] f_addr = sh[FW-1 -: AW];
  wire          f_rw   = sh[DW+1];
  wire [DW-1:0] f_data = sh[DW-1:0];
  wire          commit = frm_n && !latch_q && (cnt == FULL);
  wire          accept = commit && (f_rw || f_addr <= LAST_CTRL);

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      cnt <= '0;
      latch_q <= 1'b1;
      ev_tgl <= 1'b0;
      ev_rw <= 1'b0;
      ev_addr_r <= '0;
      for (int i = 0; i < NCTRL; i++) bank[i] <= CTRL_INIT[i*DW +: DW];
    end else begin
      latch_q <= frm_n;
      if (!frm_n) begin
        sh <= {sh[FW-2:0], sdi};
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (accept) begin
          ev_tgl <= ~ev_tgl;
          ev_rw <= f_rw;
          ev_addr_r <= f_addr;
          if (!f_rw) bank[f_addr] <= f_data;
        end
      end
    end
  end

  wire [AW-1:0] h_addr = sh[HDR-1:2];
  wire          h_rw   = sh[1];
  wire [SW-1:0] s_idx  = SW'(h_addr - AW'(NCTRL));
  wire [DW-1:0] rd_val = (h_addr <= LAST_CTRL) ? bank[h_addr] : stat[s_idx];

  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) tx <= '0;
    else if (frm_n) tx <= '0;
    else if (cnt == CW'(HDR) && h_rw) tx <= rd_val;
    else tx <= {tx[DW-2:0], 1'b0};
  end

  assign sdo = tx[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else sy <= {sy[1:0], ev_tgl};
  end

  wire pulse = sy[2] ^ sy[1];
  assign wr_stb = pulse && !ev_rw;
  assign rd_ack = pulse && ev_rw;
  assign ev_addr = ev_addr_r;

  // R2
  bank_stable_chk: assert property (@(posedge sck) disable iff (!rst_n)
    !commit |=> $stable(ctrl_out));
  // R7
  ro_write_chk: assert property (@(posedge sck) disable iff (!rst_n)
    (commit && !f_rw && f_addr > LAST_CTRL) |=> $stable(ctrl_out));
  // R8
  cnt_bound_chk: assert property (@(posedge sck) disable iff (!rst_n)
    cnt <= OVER);
  // R9
  sdo_idle_chk: assert property (@(posedge sck) disable iff (!rst_n)
    (latch_q && frm_n) |-> !sdo);
  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: tb/ctl_spi_regs_test.sv
module ctl_spi_regs_test;
  function automatic logic [119:0] mk_init();
    logic [119:0] v;
    for (int i = 0; i < 12; i++) v[i*10 +: 10] = 10'(i * 37 + 5);
    return v;
  endfunction
  localparam logic [119:0] INIT = mk_init();

  logic clk = 0, sck = 0, rst_n = 0, frm_n = 1, sdi = 0;
  logic [39:0] status_in = {10'h2A5, 10'h0F0, 10'h3C1, 10'h11B};
  logic sdo, wr_stb, rd_ack;
  logic [119:0] ctrl_out;
  logic [3:0] ev_addr;
  int checks = 0, failures = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [119:0] model;
  logic [9:0] rx;
  bit done = 0;

  ctl_spi_regs #(.CTRL_INIT(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .frm_n(frm_n), .sdi(sdi), .sdo(sdo),
    .status_in(status_in), .ctrl_out(ctrl_out), .wr_stb(wr_stb),
    .rd_ack(rd_ack), .ev_addr(ev_addr));

  always #5 clk = ~clk;
  always #60 sck = ~sck;

  always @(negedge clk) begin
    if (wr_stb) begin wr_cnt++; wr_addr = ev_addr; end
    if (rd_ack) begin rd_cnt++; rd_addr = ev_addr; end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nb);
    rx = '0;
    @(negedge sck);
    frm_n = 0;
    for (int i = 0; i < nb; i++) begin
      if (i > 0) @(negedge sck);
      sdi = (i < 16) ? w[15-i] : 1'b0;
      @(posedge sck);
      #1;
      if (i >= 6 && i < 16) rx = {rx[8:0], sdo};
    end
    @(negedge sck);
    frm_n = 1;
    sdi = 0;
    repeat (4) @(negedge sck);
  endtask

  function automatic logic [15:0] word(input logic [3:0] a, input bit rd, input logic [9:0] d);
    return {a, rd, 1'b0, d};
  endfunction

  task automatic t_reset;
    chk("R1 defaults", ctrl_out, INIT);
    chk("R9 sdo idle", sdo, 1'b0);
    chk("R5 no strobe", wr_cnt, 0);
  endtask

  task automatic t_write;
    frame(word(4'd3, 0, 10'h155), 16);
    model[30 +: 10] = 10'h155;
    chk("R2 write reg3", ctrl_out, model);
    chk("R5 wr count", wr_cnt, 1);
    chk("R5 wr addr", wr_addr, 4'd3);
  endtask

  task automatic t_edges;
    frame({4'd0, 1'b0, 1'b1, 10'h3FF}, 16);
    model[0 +: 10] = 10'h3FF;
    frame(word(4'd11, 0, 10'h201), 16);
    model[110 +: 10] = 10'h201;
    chk("R2 write reg0 and reg11", ctrl_out, model);
    chk("R5 wr count edges", wr_cnt, 3);
    chk("R5 wr addr 11", wr_addr, 4'd11);
  endtask

  task automatic t_read;
    frame(word(4'd3, 1, 10'h000), 16);
    chk("R3 read reg3", rx, 10'h155);
    chk("R6 rd count", rd_cnt, 1);
    chk("R6 rd addr", rd_addr, 4'd3);
    chk("R2 read keeps bank", ctrl_out, model);
    chk("R9 sdo idle after read", sdo, 1'b0);
    frame(word(4'd11, 1, 10'h3FF), 16);
    chk("R3 read reg11", rx, 10'h201);
  endtask

  task automatic t_status;
    frame(word(4'd13, 1, 10'h000), 16);
    chk("R4 read status 13", rx, status_in[10 +: 10]);
    frame(word(4'd15, 1, 10'h000), 16);
    chk("R4 read status 15", rx, status_in[30 +: 10]);
    chk("R6 rd addr 15", rd_addr, 4'd15);
    chk("R6 rd count status", rd_cnt, 4);
  endtask

  task automatic t_ro_write;
    frame(word(4'd14, 0, 10'h0AA), 16);
    chk("R7 ro write ignored", ctrl_out, model);
    chk("R7 no strobe", wr_cnt, 3);
    frame(word(4'd14, 1, 10'h000), 16);
    chk("R7 status unchanged", rx, status_in[20 +: 10]);
  endtask

  task automatic t_bad_len;
    frame(word(4'd5, 0, 10'h2C3), 10);
    chk("R8 short frame", ctrl_out, model);
    frame(word(4'd5, 0, 10'h2C3), 17);
    chk("R8 long frame", ctrl_out, model);
    chk("R8 no wr", wr_cnt, 3);
    frame(word(4'd2, 1, 10'h000), 15);
    chk("R8 no rd ack", rd_cnt, 5);
  endtask

  task automatic t_rereset;
    @(negedge sck);
    rst_n = 0;
    #200;
    chk("R1 reset restores", ctrl_out, INIT);
    rst_n = 1;
    repeat (2) @(negedge sck);
    chk("R1 after release", ctrl_out, INIT);
  endtask

  initial begin
    model = INIT;
    #305 rst_n = 1;
    repeat (2) @(negedge sck);
    t_reset();
    t_write();
    t_edges();
    t_read();
    t_status();
    t_ro_write();
    t_bad_len();
    t_rereset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule